// File: doc/BRIEF.md
# I2C Master START/STOP Condition Generator

This block produces the START and STOP conditions of an I2C master on open-drain SCL and SDA lines. A CPU starts either condition by writing a mode and busy code into an 8-bit status/command register. The condition is not requested through a separate command register. The block counts setup time, hold time and the delay before the bus-busy flag changes in system clock cycles. A speed-select input chooses between a standard and a high-speed set of counts, and the block samples it on the write that starts the sequence.

When a START is accepted, the block clears a 3-bit bit counter. When the START completes, with SCL pulled low, it gives a one-cycle pulse that tells the byte engine to clock one byte. The byte engine advances the bit counter through a tick input. Byte shifting, acknowledge handling, arbitration and slave address matching are done elsewhere. Their flags only pass through to the low half of the register when it is read.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, the register reads 0x10 with the four flag inputs low: mode 00, busy 0, PIN 1. Both pull outputs are 0 and the bit counter is 0.
- R2: The register bits are: bit 7 master, bit 6 transmit, bit 5 bus busy, bit 4 PIN (active low: 0 means interrupt pending), and bits 3..0 follow the arbitration, address-match, general-call and last-bit inputs. A write that is not a trigger updates bits 7, 6 and 4 only. Bit 5 and bits 3..0 ignore writes.
- R3: With the enable at 1 and standard speed, a write whose bits 7..5 are 111 starts a START. The block pulls SDA low 20 cycles after the write edge while SCL is released, then pulls SCL low 20 cycles after that.
- R4: At high speed, the same START and STOP sequences use 10 cycles of setup and 10 cycles of hold.
- R5: Bus busy goes to 1 a fixed delay after a START write and goes to 0 the same delay after a STOP write. The delay is 12 cycles at standard speed and 6 cycles at high speed.
- R6: With the enable at 1, a write whose bits 7..5 are 110 starts a STOP. SDA is held low from the write edge, SCL is released after the setup count, and SDA is released after a further hold count.
- R7: An accepted START clears the bit counter to 0. Each bit tick adds one, wrapping from 7 to 0. The byte-start output pulses for exactly one cycle, on the edge where the START pulls SCL low.
- R8: A trigger write made while the enable is 0, or while a sequence is running, changes nothing: not the register and not the lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable; START and STOP are only accepted when this is 1 |
| fast_mode | input | 1 | 1 selects the high-speed counts, 0 the standard counts |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| al_flag | input | 1 | Arbitration-lost flag from the byte engine (bit 3) |
| aas_flag | input | 1 | Address-match flag (bit 2) |
| ad0_flag | input | 1 | General-call flag (bit 1) |
| lrb_flag | input | 1 | Last received bit (bit 0) |
| bit_tick | input | 1 | Advances the bit counter by one |
| bit_cnt | output | 3 | Bit counter |
| byte_go | output | 1 | One-cycle request to clock one byte |
| bus_busy | output | 1 | Bus-busy flag |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
If the cycle counter or the latched speed holds a wrong value, the SDA or SCL edge moves away from its expected cycle, and the per-cycle trace comparison flags it on that same cycle. If the sequence state is wrong, the fault shows up in one of three ways: the busy flag changes at a time other than its fixed delay, a trigger write that should be ignored changes the register readback or the lines, or a START pulls SCL low without the one-cycle byte pulse. Each of these shows up within one sequence length, 45 cycles at most. If the bit counter fails to clear, the bench sees it on the first clock after the START write.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_STOP  = 2'd2
  } seq_e;

  localparam int REG_W   = 8;
  localparam int BIT_MST = 7;
  localparam int BIT_TRX = 6;
  localparam int BIT_BB  = 5;
  localparam int BIT_PIN = 4;
  localparam int FLAG_W  = 4;
endpackage

// File: rtl/cond_csr.sv
module cond_csr
  import i2c_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              if_en,
  input  logic              busy,
  input  logic              bb,
  input  logic [FLAG_W-1:0] flags,
  output logic              start_req,
  output logic              stop_req,
  output logic [REG_W-1:0]  rd_data
);
  logic mst_q, trx_q, pin_q;
  logic mst_d, trx_d, pin_d;
  logic trig, accept, upd;
  logic unused_wr_low;

  assign unused_wr_low = ^{wr_data[BIT_BB], wr_data[FLAG_W-1:0]};

  assign trig      = wr_en && wr_data[BIT_MST] && wr_data[BIT_TRX];
  assign accept    = trig && if_en && !busy;
  assign start_req = accept && wr_data[BIT_BB];
  assign stop_req  = accept && !wr_data[BIT_BB];
  assign upd       = wr_en && (!trig || accept);

  always_comb begin
    mst_d = mst_q;
    trx_d = trx_q;
    pin_d = pin_q;
    if (upd) begin
      mst_d = wr_data[BIT_MST];
      trx_d = wr_data[BIT_TRX];
      pin_d = wr_data[BIT_PIN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= 1'b0;
      trx_q <= 1'b0;
      pin_q <= 1'b1;
    end else begin
      mst_q <= mst_d;
      trx_q <= trx_d;
      pin_q <= pin_d;
    end
  end

  assign rd_data = {mst_q, trx_q, bb, pin_q, flags};

  assert_ignored_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !(if_en && !busy)) |=> $stable({mst_q, trx_q, pin_q}));

  assert_plain_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !trig) |=> (mst_q == $past(wr_data[BIT_MST])) && (pin_q == $past(wr_data[BIT_PIN])));
endmodule

// File: rtl/cond_timer.sv
module cond_timer #(
  parameter int SU_STD   = 20,
  parameter int HD_STD   = 20,
  parameter int BB_STD   = 12,
  parameter int SU_FAST  = 10,
  parameter int HD_FAST  = 10,
  parameter int BB_FAST  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic fast_sel,
  output logic hit_bb,
  output logic hit_a,
  output logic hit_b
);
  localparam int TOT_STD  = SU_STD + HD_STD;
  localparam int TOT_FAST = SU_FAST + HD_FAST;
  localparam int TOT_MAX  = (TOT_STD > TOT_FAST) ? TOT_STD : TOT_FAST;
  localparam int CNT_W    = $clog2(TOT_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fast_q, fast_d;
  logic [CNT_W-1:0] lim_a, lim_b, lim_bb;

  always_comb begin
    cnt_d  = cnt_q;
    fast_d = fast_q;
    if (load) begin
      cnt_d  = '0;
      fast_d = fast_sel;
    end else if (run) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fast_q <= fast_d;
    end
  end

  assign lim_a  = fast_q ? CNT_W'(SU_FAST - 1)  : CNT_W'(SU_STD - 1);
  assign lim_b  = fast_q ? CNT_W'(TOT_FAST - 1) : CNT_W'(TOT_STD - 1);
  assign lim_bb = fast_q ? CNT_W'(BB_FAST - 1)  : CNT_W'(BB_STD - 1);

  assign hit_a  = run && (cnt_q == lim_a);
  assign hit_b  = run && (cnt_q == lim_b);
  assign hit_bb = run && (cnt_q == lim_bb);

  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= CNT_W'(TOT_MAX - 1)));

  assert_speed_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(fast_q));
endmodule

// File: rtl/cond_seq.sv
module cond_seq
  import i2c_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       hit_bb,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       bit_tick,
  output logic       busy,
  output logic       bb,
  output logic       scl_low,
  output logic       sda_low,
  output logic       byte_go,
  output logic [2:0] bit_cnt
);
  seq_e       kind_q, kind_d;
  logic       bb_q, bb_d;
  logic       scl_q, scl_d;
  logic       sda_q, sda_d;
  logic       go_q, go_d;
  logic [2:0] bc_q, bc_d;

  always_comb begin
    kind_d = kind_q;
    bb_d   = bb_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    go_d   = 1'b0;
    bc_d   = bit_tick ? bc_q + 3'd1 : bc_q;
    case (kind_q)
      SEQ_IDLE: begin
        if (start_req) begin
          kind_d = SEQ_START;
          bc_d   = 3'd0;
        end else if (stop_req) begin
          kind_d = SEQ_STOP;
          sda_d  = 1'b1;
        end
      end
      SEQ_START: begin
        if (hit_bb) bb_d  = 1'b1;
        if (hit_a)  sda_d = 1'b1;
        if (hit_b) begin
          scl_d  = 1'b1;
          go_d   = 1'b1;
          kind_d = SEQ_IDLE;
        end
      end
      SEQ_STOP: begin
        if (hit_bb) bb_d  = 1'b0;
        if (hit_a)  scl_d = 1'b0;
        if (hit_b) begin
          sda_d  = 1'b0;
          kind_d = SEQ_IDLE;
        end
      end
      default: kind_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= SEQ_IDLE;
      bb_q   <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      go_q   <= 1'b0;
      bc_q   <= 3'd0;
    end else begin
      kind_q <= kind_d;
      bb_q   <= bb_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      go_q   <= go_d;
      bc_q   <= bc_d;
    end
  end

  assign busy    = (kind_q != SEQ_IDLE);
  assign bb      = bb_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;
  assign byte_go = go_q;
  assign bit_cnt = bc_q;

  assert_start_edge_scl_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_q) && kind_q == SEQ_START) |-> !scl_q);

  assert_stop_edge_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_q) |-> !scl_q);

  assert_byte_go_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> (scl_q && sda_q && kind_q == SEQ_IDLE));

  assert_counter_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == SEQ_IDLE && start_req) |=> (bc_q == 3'd0));

  assert_bb_rise_in_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bb_q) |-> ($past(kind_q) == SEQ_START));

  assert_bb_fall_in_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bb_q) |-> ($past(kind_q) == SEQ_STOP));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int SU_STD  = 20,
  parameter int HD_STD  = 20,
  parameter int BB_STD  = 12,
  parameter int SU_FAST = 10,
  parameter int HD_FAST = 10,
  parameter int BB_FAST = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic       fast_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       al_flag,
  input  logic       aas_flag,
  input  logic       ad0_flag,
  input  logic       lrb_flag,
  input  logic       bit_tick,
  output logic [2:0] bit_cnt,
  output logic       byte_go,
  output logic       bus_busy,
  output logic       scl_pull,
  output logic       sda_pull
);
  logic start_req, stop_req, busy, bb;
  logic hit_bb, hit_a, hit_b;

  cond_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .if_en     (if_en),
    .busy      (busy),
    .bb        (bb),
    .flags     ({al_flag, aas_flag, ad0_flag, lrb_flag}),
    .start_req (start_req),
    .stop_req  (stop_req),
    .rd_data   (rd_data)
  );

  cond_timer #(
    .SU_STD (SU_STD),  .HD_STD (HD_STD),  .BB_STD (BB_STD),
    .SU_FAST(SU_FAST), .HD_FAST(HD_FAST), .BB_FAST(BB_FAST)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_req || stop_req),
    .run      (busy),
    .fast_sel (fast_mode),
    .hit_bb   (hit_bb),
    .hit_a    (hit_a),
    .hit_b    (hit_b)
  );

  cond_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .hit_bb    (hit_bb),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .bit_tick  (bit_tick),
    .busy      (busy),
    .bb        (bb),
    .scl_low   (scl_pull),
    .sda_low   (sda_pull),
    .byte_go   (byte_go),
    .bit_cnt   (bit_cnt)
  );

  assign bus_busy = bb;

  assert_readback_bb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_BB] == bus_busy);

  assert_no_accept_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !if_en) |=> $stable({scl_pull, sda_pull}));
endmodule

// File: tb/test_i2c_cond_gen.sv
`timescale 1ns/1ps
module test_i2c_cond_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       if_en, fast_mode, wr_en, bit_tick;
  logic [7:0] wr_data, rd_data;
  logic       al_flag, aas_flag, ad0_flag, lrb_flag;
  logic [2:0] bit_cnt;
  logic       byte_go, bus_busy, scl_pull, sda_pull;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [3:0] v;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  i2c_cond_gen i_i2c_cond_gen (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .fast_mode(fast_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .al_flag(al_flag), .aas_flag(aas_flag), .ad0_flag(ad0_flag), .lrb_flag(lrb_flag),
    .bit_tick(bit_tick), .bit_cnt(bit_cnt), .byte_go(byte_go),
    .bus_busy(bus_busy), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one expected line state {scl,sda,bb,go} per cycle
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check({4'h0, scl_pull, sda_pull, bus_busy, byte_go}, {4'h0, it.v}, it.tag);
    end
  end

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic push_idle(input int n, input string tag);
    for (int k = 0; k < n; k++) exp_q.push_back('{4'b0000, tag});
  endtask

  // Driver: writes the trigger and queues the expected trace from the accept edge
  task automatic run_seq(input logic [7:0] d, input bit is_start,
                         input int su, input int hd, input int bbd, input string tag);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    for (int k = 0; k < su + hd + 5; k++) begin
      exp_t it;
      if (is_start)
        it.v = {logic'(k >= su + hd), logic'(k >= su), logic'(k >= bbd), logic'(k == su + hd)};
      else
        it.v = {logic'(k < su), logic'(k < su + hd), logic'(k < bbd), 1'b0};
      it.tag = tag;
      exp_q.push_back(it);
    end
    #1;
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; if_en = 1'b0; fast_mode = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    bit_tick = 1'b0; al_flag = 1'b0; aas_flag = 1'b0; ad0_flag = 1'b0; lrb_flag = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_data, 8'h10, "R1 reset register");
    check({5'h0, bit_cnt}, 8'h00, "R1 reset bit counter");
    check({6'h0, scl_pull, sda_pull}, 8'h00, "R1 reset lines released");

    // R2 layout, read-only flags, BB not writable
    al_flag = 1'b1; ad0_flag = 1'b1;
    @(negedge clk);
    check(rd_data, 8'h1A, "R2 flag inputs on bits 3..0");
    do_write(8'h05);
    @(negedge clk);
    check(rd_data, 8'h0A, "R2 write ignores read-only bits");
    do_write(8'h90);
    @(negedge clk);
    check(rd_data, 8'h9A, "R2 master bit and PIN written");
    do_write(8'h20);
    @(negedge clk);
    check(rd_data, 8'h0A, "R2 BB bit not writable");
    check({6'h0, scl_pull, sda_pull}, 8'h00, "R2 lines untouched by plain write");

    // R8 trigger ignored while disabled
    do_write(8'hF0);
    push_idle(10, "R8 disabled START leaves lines");
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(rd_data, 8'h0A, "R8 disabled START leaves register");

    // R3 R5 R7 standard START, with an ignored STOP write mid-sequence (R8)
    if_en = 1'b1;
    run_seq(8'hF0, 1'b1, 20, 20, 12, "R3 R5 R7 standard START trace");
    repeat (5) @(negedge clk);
    do_write(8'hC0);
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(rd_data, 8'hFA, "R8 write during START ignored, R5 BB set");
    check({5'h0, bit_cnt}, 8'h00, "R7 counter cleared by START");

    // R7 bit counter increment and wrap
    tick(3);
    @(negedge clk);
    check({5'h0, bit_cnt}, 8'h03, "R7 counter after three ticks");
    tick(8);
    @(negedge clk);
    check({5'h0, bit_cnt}, 8'h03, "R7 counter wraps after eight ticks");

    // R6 R5 standard STOP
    run_seq(8'hD0, 1'b0, 20, 20, 12, "R6 R5 standard STOP trace");
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(rd_data, 8'hDA, "R6 register after STOP");

    // R4 high-speed START, counter cleared on accept edge
    fast_mode = 1'b1;
    run_seq(8'hF0, 1'b1, 10, 10, 6, "R4 R5 fast START trace");
    @(negedge clk);
    check({5'h0, bit_cnt}, 8'h00, "R7 counter cleared on START accept");
    wait (exp_q.size() == 0);

    // R4 high-speed STOP
    run_seq(8'hD0, 1'b0, 10, 10, 6, "R4 R5 fast STOP trace");
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(rd_data, 8'hDA, "R4 register after fast STOP");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule